// File: doc/BRIEF.md
# CMI Line Encoder with Violation Insertion

This block turns a serial NRZ bit stream into Coded Mark Inversion line code. It runs on a line clock at twice the bit rate. It takes one data bit, together with the mode selection, on every second rising edge, and it emits that bit as two half-bit symbols on a single output. A zero is coded as a low half followed by a high half. A one is coded as a flat level held for the whole bit, and that level alternates from one `1` to the next. When the 3-bit mode input selects a non-CMI mode, the encoder steps aside and the NRZ bit is driven on both halves.

For line diagnostics, a rising edge on an asynchronous request input marks exactly one later bit as a code violation:
- On a zero bit, the violation is the inverted zero symbol.
- On a one bit, the violation repeats the level of the previous one.

Later ones alternate from the level that was actually sent, so the injected error is the only error on the line.

Top module: `cmi_line_encoder`

## Requirements
- R1: In CMI mode, a zero bit without a violation is sent low in its first half and high in its second half.
- R2: In CMI mode, a one bit is held at one level for both halves. Successive ones alternate in level, counted only across ones sent in CMI mode.
- R3: `bit_strobe_o` is high in every second cycle. The rising edge that ends a strobe-high cycle samples `data_i` and `mode_i`. The first half of that bit is on `line_o` in the next cycle and the second half in the cycle after that. The first edge after reset is a sampling edge.
- R4: `mode_i` values 3'b100 and 3'b101 select CMI. Every other value selects bypass, in which `line_o` equals the sampled data bit for both halves.
- R5: A change on `mode_i` in the first-half cycle of a bit does not alter that bit's second half.
- R6: Each rising edge of `viol_req_i` produces exactly one violation, however long the request stays high. With the default of two sync stages, a request that rises together with the presentation of bit k marks bit k+2.
- R7: A violation on a zero bit in CMI mode is sent high then low.
- R8: A violation on a one bit in CMI mode repeats the previous one's level. The next one alternates from that repeated level.
- R9: A violation whose marked bit is sent in bypass is discarded and does not move to a later bit.
- R10: During and after reset, `line_o` is low and `bit_strobe_o` is high. The first CMI one after reset is sent high, and no violation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock, twice the bit rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | NRZ data bit, sampled at the end of a strobe cycle |
| mode_i | input | 3 | Operating mode; 3'b100 and 3'b101 select CMI |
| viol_req_i | input | 1 | Asynchronous violation request, acts on its rising edge |
| line_o | output | 1 | Encoded line output, one half-bit per cycle |
| bit_strobe_o | output | 1 | High in the cycle whose closing edge takes the next bit |

## Verification
Each bit is presented in a strobe-high cycle. Its first half is due one cycle after the sampling edge and its second half two cycles after it. The bench samples `line_o` on the falling edge in each of those two cycles and compares both halves against an arithmetic model of the code.

A violation request is raised together with bit k. The bench model applies the violation to bit k+2, which covers the three register stages between the request pin and the symbol register. The model also decides, from the mode of bit k+2, whether the violation is sent or dropped. Mid-bit mode changes are applied in the first-half cycle, after the sampling edge, so they land in the one window where the design must ignore them.

// File: rtl/cmi_pkg.sv
package cmi_pkg;
  localparam int unsigned MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_CMI_A = 3'b100;
  localparam logic [MODE_W-1:0] MODE_CMI_B = 3'b101;
  // symbol bit 1 = first half, bit 0 = second half
  localparam logic [1:0] SYM_ZERO     = 2'b01;
  localparam logic [1:0] SYM_ZERO_INV = 2'b10;

  function automatic logic is_cmi(input logic [MODE_W-1:0] m);
    return (m == MODE_CMI_A) || (m == MODE_CMI_B);
  endfunction
endpackage

// File: rtl/cmi_req_sync.sv
module cmi_req_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic consume_i,
  output logic pend_o
);
  logic [SYNC_STAGES:0] chain_q;
  logic                 rise;
  logic                 pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-1:0], req_i};
  end

  assign rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // a fresh edge wins over a consume on the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pend_q <= 1'b0;
    else if (rise)      pend_q <= 1'b1;
    else if (consume_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;

  p_one_shot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (consume_i && !rise) |=> !pend_o);
endmodule

// File: rtl/cmi_sym_enc.sv
module cmi_sym_enc (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic       cmi_i,
  input  logic       bit_i,
  input  logic       viol_i,
  output logic [1:0] sym_o,
  output logic       ones_lvl_o
);
  import cmi_pkg::*;

  logic       lvl_q, lvl_nxt;
  logic [1:0] sym_q, sym_n;

  always_comb begin
    lvl_nxt = viol_i ? lvl_q : ~lvl_q;
    if (!cmi_i)     sym_n = {bit_i, bit_i};
    else if (bit_i) sym_n = {lvl_nxt, lvl_nxt};
    else            sym_n = viol_i ? SYM_ZERO_INV : SYM_ZERO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q <= 2'b00;
      lvl_q <= 1'b0;
    end else if (load_i) begin
      sym_q <= sym_n;
      if (cmi_i && bit_i) lvl_q <= lvl_nxt;
    end
  end

  assign sym_o      = sym_q;
  assign ones_lvl_o = lvl_q;

  p_lvl_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && cmi_i && bit_i && viol_i) |=> (lvl_q == $past(lvl_q)));
endmodule

// File: rtl/cmi_line_encoder.sv
module cmi_line_encoder #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      data_i,
  input  logic [cmi_pkg::MODE_W-1:0] mode_i,
  input  logic                      viol_req_i,
  output logic                      line_o,
  output logic                      bit_strobe_o
);
  import cmi_pkg::*;

  logic       ph_q;   // 1: second half, next edge loads a bit
  logic       load, cmi_sel, pend, ones_lvl;
  logic [1:0] sym;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ph_q <= 1'b1;
    else         ph_q <= ~ph_q;
  end

  assign load    = ph_q;
  assign cmi_sel = is_cmi(mode_i);

  cmi_req_sync #(.SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (viol_req_i),
    .consume_i (load),
    .pend_o    (pend)
  );

  cmi_sym_enc u_enc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .cmi_i      (cmi_sel),
    .bit_i      (data_i),
    .viol_i     (pend & cmi_sel),
    .sym_o      (sym),
    .ones_lvl_o (ones_lvl)
  );

  assign line_o       = ph_q ? sym[0] : sym[1];
  assign bit_strobe_o = ph_q;

  p_zero_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_strobe_o && cmi_sel && !data_i && !pend) |=> (!line_o ##1 line_o));
  p_one_alt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_strobe_o && cmi_sel && data_i && !pend) |=> (line_o == !$past(ones_lvl)));
  p_one_flat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_strobe_o && cmi_sel && data_i) |=> ##1 $stable(line_o));
  p_bypass_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_strobe_o && !cmi_sel) |=> (line_o == $past(data_i)));
  p_viol_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_strobe_o && cmi_sel && !data_i && pend) |=> (line_o ##1 !line_o));
  p_viol_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_strobe_o && cmi_sel && data_i && pend) |=> (line_o == $past(ones_lvl)));
endmodule

// File: tb/cmi_line_encoder_test.sv
module cmi_line_encoder_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] M_A = 3'b100;
  localparam logic [2:0] M_B = 3'b101;
  localparam logic [2:0] M_BYP = 3'b000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic data_i = 1'b0;
  logic [2:0] mode_i = M_A;
  logic viol_req_i = 1'b0;
  logic line_o, bit_strobe_o;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic m_lvl = 1'b0;
  logic m_rprev = 1'b0;
  logic m_v0 = 1'b0;
  logic m_v1 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmi_line_encoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .mode_i(mode_i),
    .viol_req_i(viol_req_i), .line_o(line_o), .bit_strobe_o(bit_strobe_o)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s got %0b exp %0b", tag, what, act, exp);
    end
  endtask

  // called at a falling edge in a strobe-high cycle
  task automatic send(input logic d, input logic [2:0] m, input logic r,
                      input logic [2:0] m_mid, input string tag_in);
    logic cmi, v, f, s;
    string tag;
    cmi = (m == M_A) || (m == M_B);
    v = m_v1;
    m_v1 = m_v0;
    m_v0 = r && !m_rprev;
    m_rprev = r;
    if (!cmi) begin
      f = d; s = d; tag = "R4";
    end else if (d) begin
      f = v ? m_lvl : !m_lvl; s = f; m_lvl = f; tag = v ? "R8" : "R2";
    end else begin
      f = v; s = !v; tag = v ? "R7" : "R1";
    end
    if (tag_in != "") tag = tag_in;
    data_i = d; mode_i = m; viol_req_i = r;
    chk("R3", "strobe before load", bit_strobe_o, 1'b1);
    @(posedge clk); @(negedge clk);
    chk(tag, "first half", line_o, f);
    chk("R3", "strobe first half", bit_strobe_o, 1'b0);
    mode_i = m_mid;
    @(posedge clk); @(negedge clk);
    chk(tag, "second half", line_o, s);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: run hung got 1 exp 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "line in reset", line_o, 1'b0);
    chk("R10", "strobe in reset", bit_strobe_o, 1'b1);
    rst_ni = 1'b1;
    chk("R10", "line after reset", line_o, 1'b0);
    send(1'b1, M_A, 1'b0, M_A, "R10");   // first one goes high
    send(1'b0, M_A, 1'b0, M_A, "");

    // exhaustive byte patterns through both CMI modes
    for (int p = 0; p < 256; p++)
      for (int b = 7; b >= 0; b--)
        send(p[b], p[0] ? M_B : M_A, 1'b0, p[0] ? M_B : M_A, "");

    // every mode value, mixed data
    for (int m = 0; m < 8; m++)
      for (int b = 0; b < 4; b++)
        send((b != 1), 3'(m), 1'b0, 3'(m), "");

    // mid-bit mode changes
    send(1'b1, M_A, 1'b0, M_BYP, "R5");
    send(1'b0, M_A, 1'b0, M_BYP, "R5");
    send(1'b0, M_BYP, 1'b0, M_A, "R5");
    send(1'b1, M_BYP, 1'b0, M_B, "R5");

    // violations landing on each data pattern of a 4-bit window
    for (int t = 0; t < 16; t++) begin
      send(t[0], M_A, 1'b1, M_A, "");
      send(t[1], M_A, 1'b0, M_A, "");
      send(t[2], M_A, 1'b0, M_A, "");
      send(t[3], M_A, 1'b0, M_A, "");
      send(1'b1, M_A, 1'b0, M_A, "");
      send(1'b1, M_A, 1'b0, M_A, "");
    end

    // one violation on a one, then ones keep alternating (R8)
    send(1'b1, M_A, 1'b1, M_A, "");
    send(1'b1, M_A, 1'b0, M_A, "");
    for (int i = 0; i < 5; i++) send(1'b1, M_A, 1'b0, M_A, "R8");

    // held request: single violation only (R6)
    for (int i = 0; i < 8; i++) send(i[0], M_A, 1'b1, M_A, "R6");
    for (int i = 0; i < 4; i++) send(1'b1, M_A, 1'b0, M_A, "R6");

    // violation marked onto a bypass bit is dropped (R9)
    send(1'b0, M_A, 1'b1, M_A, "R9");
    send(1'b0, M_A, 1'b0, M_A, "R9");
    send(1'b0, M_BYP, 1'b0, M_BYP, "R9");
    for (int i = 0; i < 4; i++) send(i[0], M_A, 1'b0, M_A, "R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule